// File: doc/BRIEF.md
# NAND Device Identification Probe

After power-up this block finds out what kind of NAND device is attached and how large it is. It drives a small command sequencer through an operation port. Each operation is a command byte, an address byte or a one-byte read, and each read returns its byte on a separate read-data port. When `start` is pulsed, the probe resets the device and reads the identifier twice. It stops with an error if the manufacturer and device bytes differ between the two reads. It then checks the four-byte parameter-page signature, and on success reads the parameter page to obtain the device geometry.

The parameter page is consumed as a byte stream. Only the few little-endian size fields are kept; every other byte is read and dropped, so the block needs no page buffer. Block size and chip size come from a multi-cycle shift-add multiplier. The page and erase shift amounts are the positions of the lowest set bit. When the probe ends it reports either success together with the geometry outputs, or an error code with all geometry outputs at zero.

Top module: `onfi_probe`

## Requirements
- R1: After reset, `busy`, `done` and `ok` are 0, `err_code` is 0 and every geometry output is 0.
- R2: While the probe is not busy, a `start` pulse begins a probe. The first operation is a command (op_kind 0) with byte 0xFF. It is followed by command 0x90, address (op_kind 1) 0x00 and two reads (op_kind 2) that capture the manufacturer and device bytes. A `start` pulse while busy has no effect.
- R3: A second command 0x90 with address 0x00 is followed by exactly eight reads. If read 0 differs from the manufacturer byte or read 1 differs from the device byte, the probe ends with `err_code` 1 and issues no further operation.
- R4: Command 0x90 with address 0x20 is followed by reads that are compared in order with 0x4F, 0x4E, 0x46, 0x49. The first byte that differs ends the probe with `err_code` 2, and no further read or command is issued.
- R5: After a good signature the probe issues command 0xEC, address 0x00 and reads bytes 0 to 100 of the parameter page. It takes these little-endian fields: page bytes at offset 80 (4 bytes), spare bytes at 84 (2 bytes), pages per block at 92 (4 bytes), blocks per unit at 96 (4 bytes) and unit count at 100 (1 byte).
- R6: `block_size` is pages per block times page size, truncated to 32 bits. `chip_size` is blocks per unit times block size times unit count, held in 64 bits.
- R7: `page_shift` and `erase_shift` are the index of the lowest set bit of `page_size` and of `block_size`.
- R8: `page_mask` equals `chip_size` shifted right by `page_shift`, minus one.
- R9: An operation holds `op_kind` and `op_byte` stable until `op_ready` is seen. After a read is accepted, no operation is presented until its `rd_valid` byte arrives.
- R10: At the end of a probe, `done` rises and `busy` falls, and they stay that way until the next `start`. On success `ok` is 1 and `err_code` is 0. On an error `ok` is 0 and all geometry outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| op_valid | output | 1 | Operation presented to the sequencer |
| op_ready | input | 1 | Sequencer accepts the operation this cycle |
| op_kind | output | 2 | 0 command, 1 address, 2 read |
| op_byte | output | 8 | Command or address byte |
| rd_valid | input | 1 | Byte of an accepted read is on rd_data |
| rd_data | input | 8 | Read byte |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished |
| ok | output | 1 | Probe finished with a valid device |
| err_code | output | 2 | 0 none, 1 identifier mismatch, 2 signature missing |
| page_size | output | 32 | Bytes per page |
| spare_size | output | 16 | Spare bytes per page |
| block_size | output | 32 | Bytes per erase block |
| chip_size | output | 64 | Bytes per device |
| page_shift | output | 5 | Lowest set bit index of page_size |
| erase_shift | output | 5 | Lowest set bit index of block_size |
| page_mask | output | 64 | Pages per device minus one |

## Verification
A wrong byte counter or phase register appears at the ports within one operation. It shows up as an extra or missing read, a command byte out of order, or an error code raised on a good device, and the bench catches these by logging every accepted operation. A field captured into the wrong lane, or a multiplier that stops one step early or late, does not affect the operation stream at all. It appears only at `done`, as geometry that disagrees with values the bench computes from the page contents it served. Using several geometries, including one whose page size is not a power of two, keeps a wrong shift amount from matching by coincidence.

// File: rtl/onfi_probe_pkg.sv
package onfi_probe_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_READ = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ID_DIFF  = 2'd1,
        ERR_NO_SIG   = 2'd2
    } err_e;

    typedef enum logic [4:0] {
        PH_IDLE, PH_RST,
        PH_ID1_CMD, PH_ID1_ADR, PH_ID1_RD,
        PH_ID2_CMD, PH_ID2_ADR, PH_ID2_RD,
        PH_SIG_CMD, PH_SIG_ADR, PH_SIG_RD,
        PH_PAR_CMD, PH_PAR_ADR, PH_PAR_RD,
        PH_MUL_BLK, PH_MUL_LUN_BLK, PH_MUL_LUNS,
        PH_FIN, PH_DONE
    } phase_e;

    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_PARAMS  = 8'hEC;
    localparam logic [7:0] ADR_ID      = 8'h00;
    localparam logic [7:0] ADR_SIG     = 8'h20;
    localparam logic [7:0] ADR_PAGE0   = 8'h00;

    localparam int ID_REPEAT_LEN = 8;
    localparam int SIG_LEN       = 4;

    // parameter page byte offsets (all word aligned)
    localparam int OFS_PAGE_BYTES = 80;
    localparam int OFS_SPARE      = 84;
    localparam int OFS_PPB        = 92;
    localparam int OFS_BPU        = 96;
    localparam int OFS_UNITS      = 100;

    function automatic logic [7:0] sig_char(input logic [1:0] pos);
        case (pos)
            2'd0:    return 8'h4F;
            2'd1:    return 8'h4E;
            2'd2:    return 8'h46;
            default: return 8'h49;
        endcase
    endfunction

endpackage

// File: rtl/onfi_shift_mul.sv
module onfi_shift_mul #(
    parameter int A_W = 64,
    parameter int B_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           busy,
    output logic           done,
    output logic [A_W-1:0] prod
);
    localparam int CNT_W = $clog2(B_W + 1);

    typedef struct packed {
        logic [A_W-1:0]   acc;
        logic [A_W-1:0]   a_sh;
        logic [B_W-1:0]   b_sh;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } mul_st_t;

    mul_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start && !st_q.busy) begin
            st_d.acc  = '0;
            st_d.a_sh = a_in;
            st_d.b_sh = b_in;
            st_d.cnt  = CNT_W'(B_W);
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            if (st_q.b_sh[0]) begin
                st_d.acc = st_q.acc + st_q.a_sh;
            end
            st_d.a_sh = st_q.a_sh << 1;
            st_d.b_sh = st_q.b_sh >> 1;
            st_d.cnt  = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign prod = st_q.acc;

    AST_MUL_DONE_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R6
    AST_MUL_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R6

endmodule

// File: rtl/onfi_lsb_index.sv
module onfi_lsb_index #(
    parameter int W = 32
) (
    input  logic [W-1:0]         val,
    output logic [$clog2(W)-1:0] pos
);
    localparam int POS_W = $clog2(W);

    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (val[i]) pos = POS_W'(i);
        end
    end
endmodule

// File: rtl/onfi_probe.sv
module onfi_probe
    import onfi_probe_pkg::*;
#(
    parameter int FIELD_W = 32,
    parameter int SPARE_W = 16,
    parameter int CHIP_W  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output logic                       op_valid,
    input  logic                       op_ready,
    output logic [1:0]                 op_kind,
    output logic [7:0]                 op_byte,
    input  logic                       rd_valid,
    input  logic [7:0]                 rd_data,
    output logic                       busy,
    output logic                       done,
    output logic                       ok,
    output logic [1:0]                 err_code,
    output logic [FIELD_W-1:0]         page_size,
    output logic [SPARE_W-1:0]         spare_size,
    output logic [FIELD_W-1:0]         block_size,
    output logic [CHIP_W-1:0]          chip_size,
    output logic [$clog2(FIELD_W)-1:0] page_shift,
    output logic [$clog2(FIELD_W)-1:0] erase_shift,
    output logic [CHIP_W-1:0]          page_mask
);
    localparam int SHIFT_W = $clog2(FIELD_W);
    localparam int IDX_W   = $clog2(OFS_UNITS + 1);

    typedef struct packed {
        phase_e             phase;
        logic               wait_rd;
        logic [IDX_W-1:0]   idx;
        logic               launch;
        logic [7:0]         mfg;
        logic [7:0]         dev;
        logic               id_bad;
        logic [FIELD_W-1:0] page;
        logic [SPARE_W-1:0] spare;
        logic [FIELD_W-1:0] ppb;
        logic [FIELD_W-1:0] bpu;
        logic [7:0]         units;
        logic [FIELD_W-1:0] block;
        logic [CHIP_W-1:0]  chip;
        logic [SHIFT_W-1:0] pshift;
        logic [SHIFT_W-1:0] eshift;
        logic [CHIP_W-1:0]  pmask;
        err_e               err;
        logic               ok;
    } probe_st_t;

    probe_st_t st_d, st_q;

    logic               mul_busy, mul_done;
    logic [CHIP_W-1:0]  mul_a, mul_prod;
    logic [FIELD_W-1:0] mul_b;
    logic [SHIFT_W-1:0] page_lsb, block_lsb;
    logic [CHIP_W-1:0]  pages_total;
    logic               accept, rd_got, rd_phase;

    function automatic logic [FIELD_W-1:0] put_lane(input logic [FIELD_W-1:0] w,
                                                    input logic [1:0] lane,
                                                    input logic [7:0] b);
        logic [FIELD_W-1:0] r;
        r = w;
        case (lane)
            2'd0:    r[7:0]   = b;
            2'd1:    r[15:8]  = b;
            2'd2:    r[23:16] = b;
            default: r[31:24] = b;
        endcase
        return r;
    endfunction

    function automatic logic in_word(input logic [IDX_W-1:0] i, input int ofs);
        return {i[IDX_W-1:2], 2'b00} == IDX_W'(ofs);
    endfunction

    onfi_lsb_index #(.W(FIELD_W)) u_page_lsb  (.val(st_q.page),  .pos(page_lsb));
    onfi_lsb_index #(.W(FIELD_W)) u_block_lsb (.val(st_q.block), .pos(block_lsb));

    onfi_shift_mul #(.A_W(CHIP_W), .B_W(FIELD_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .start(st_q.launch),
        .a_in(mul_a), .b_in(mul_b),
        .busy(mul_busy), .done(mul_done), .prod(mul_prod)
    );

    assign pages_total = st_q.chip >> page_lsb;
    assign rd_phase    = (st_q.phase == PH_ID1_RD) || (st_q.phase == PH_ID2_RD) ||
                         (st_q.phase == PH_SIG_RD) || (st_q.phase == PH_PAR_RD);
    assign accept      = op_valid && op_ready;
    assign rd_got      = st_q.wait_rd && rd_valid;

    // operation presented for the current phase
    always_comb begin
        op_valid = 1'b1;
        op_kind  = OP_CMD;
        op_byte  = 8'h00;
        case (st_q.phase)
            PH_RST:     op_byte = CMD_RESET;
            PH_ID1_CMD, PH_ID2_CMD, PH_SIG_CMD: op_byte = CMD_IDENT;
            PH_PAR_CMD: op_byte = CMD_PARAMS;
            PH_ID1_ADR, PH_ID2_ADR: begin op_kind = OP_ADDR; op_byte = ADR_ID;    end
            PH_SIG_ADR: begin op_kind = OP_ADDR; op_byte = ADR_SIG;   end
            PH_PAR_ADR: begin op_kind = OP_ADDR; op_byte = ADR_PAGE0; end
            PH_ID1_RD, PH_ID2_RD, PH_SIG_RD, PH_PAR_RD: begin
                op_kind  = OP_READ;
                op_valid = !st_q.wait_rd;
            end
            default:    op_valid = 1'b0;
        endcase
    end

    // multiplier operand selection
    always_comb begin
        mul_a = CHIP_W'(st_q.page);
        mul_b = st_q.ppb;
        case (st_q.phase)
            PH_MUL_LUN_BLK: begin mul_a = CHIP_W'(st_q.block); mul_b = st_q.bpu; end
            PH_MUL_LUNS:    begin mul_a = st_q.chip; mul_b = FIELD_W'(st_q.units); end
            default: ;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;

        if (rd_phase) begin
            if (accept)      st_d.wait_rd = 1'b1;
            else if (rd_got) begin
                st_d.wait_rd = 1'b0;
                st_d.idx     = st_q.idx + IDX_W'(1);
            end
        end

        case (st_q.phase)
            PH_IDLE, PH_DONE: if (start) begin
                st_d       = '0;
                st_d.phase = PH_RST;
            end
            PH_RST:     if (accept) st_d.phase = PH_ID1_CMD;
            PH_ID1_CMD: if (accept) st_d.phase = PH_ID1_ADR;
            PH_ID1_ADR: if (accept) begin st_d.phase = PH_ID1_RD; st_d.idx = '0; end
            PH_ID1_RD:  if (rd_got) begin
                if (st_q.idx == IDX_W'(0)) st_d.mfg = rd_data;
                else begin
                    st_d.dev   = rd_data;
                    st_d.phase = PH_ID2_CMD;
                end
            end
            PH_ID2_CMD: if (accept) st_d.phase = PH_ID2_ADR;
            PH_ID2_ADR: if (accept) begin st_d.phase = PH_ID2_RD; st_d.idx = '0; end
            PH_ID2_RD:  if (rd_got) begin
                st_d.id_bad = st_q.id_bad |
                              ((st_q.idx == IDX_W'(0)) && (rd_data != st_q.mfg)) |
                              ((st_q.idx == IDX_W'(1)) && (rd_data != st_q.dev));
                if (st_q.idx == IDX_W'(ID_REPEAT_LEN - 1)) begin
                    if (st_d.id_bad) begin
                        st_d.err   = ERR_ID_DIFF;
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.phase = PH_SIG_CMD;
                    end
                end
            end
            PH_SIG_CMD: if (accept) st_d.phase = PH_SIG_ADR;
            PH_SIG_ADR: if (accept) begin st_d.phase = PH_SIG_RD; st_d.idx = '0; end
            PH_SIG_RD:  if (rd_got) begin
                if (rd_data != sig_char(st_q.idx[1:0])) begin
                    st_d.err   = ERR_NO_SIG;
                    st_d.phase = PH_DONE;
                end else if (st_q.idx == IDX_W'(SIG_LEN - 1)) begin
                    st_d.phase = PH_PAR_CMD;
                end
            end
            PH_PAR_CMD: if (accept) st_d.phase = PH_PAR_ADR;
            PH_PAR_ADR: if (accept) begin st_d.phase = PH_PAR_RD; st_d.idx = '0; end
            PH_PAR_RD:  if (rd_got) begin
                if (in_word(st_q.idx, OFS_PAGE_BYTES))
                    st_d.page = put_lane(st_q.page, st_q.idx[1:0], rd_data);
                if (in_word(st_q.idx, OFS_SPARE) && !st_q.idx[1])
                    st_d.spare = SPARE_W'(put_lane(FIELD_W'(st_q.spare), st_q.idx[1:0], rd_data));
                if (in_word(st_q.idx, OFS_PPB))
                    st_d.ppb = put_lane(st_q.ppb, st_q.idx[1:0], rd_data);
                if (in_word(st_q.idx, OFS_BPU))
                    st_d.bpu = put_lane(st_q.bpu, st_q.idx[1:0], rd_data);
                if (st_q.idx == IDX_W'(OFS_UNITS)) begin
                    st_d.units  = rd_data;
                    st_d.phase  = PH_MUL_BLK;
                    st_d.launch = 1'b1;
                end
            end
            PH_MUL_BLK: if (mul_done) begin
                st_d.block  = mul_prod[FIELD_W-1:0];
                st_d.phase  = PH_MUL_LUN_BLK;
                st_d.launch = 1'b1;
            end
            PH_MUL_LUN_BLK: if (mul_done) begin
                st_d.chip   = mul_prod;
                st_d.phase  = PH_MUL_LUNS;
                st_d.launch = 1'b1;
            end
            PH_MUL_LUNS: if (mul_done) begin
                st_d.chip  = mul_prod;
                st_d.phase = PH_FIN;
            end
            PH_FIN: begin
                st_d.pshift = page_lsb;
                st_d.eshift = block_lsb;
                st_d.pmask  = pages_total - CHIP_W'(1);
                st_d.ok     = 1'b1;
                st_d.phase  = PH_DONE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = (st_q.phase != PH_IDLE) && (st_q.phase != PH_DONE);
    assign done        = (st_q.phase == PH_DONE);
    assign ok          = st_q.ok;
    assign err_code    = st_q.err;
    assign page_size   = st_q.page;
    assign spare_size  = st_q.spare;
    assign block_size  = st_q.block;
    assign chip_size   = st_q.chip;
    assign page_shift  = st_q.pshift;
    assign erase_shift = st_q.eshift;
    assign page_mask   = st_q.pmask;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !ok); // R1
    AST_START_SENDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> op_valid && op_kind == OP_CMD && op_byte == CMD_RESET); // R2
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> op_valid && $stable(op_kind) && $stable(op_byte)); // R9
    AST_READ_BLOCKS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind == OP_READ) |=> !op_valid); // R9
    AST_NO_OP_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !op_valid); // R3
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> done && err_code == ERR_NONE); // R10
    AST_ERR_NO_GEOMETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != ERR_NONE) |-> page_size == '0 && chip_size == '0 && block_size == '0); // R10
    AST_SHIFT_HITS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && page_size != '0) |-> page_size[page_shift]); // R7

endmodule

// File: tb/onfi_probe_tb_top.sv
module onfi_probe_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_valid, op_ready = 1'b0;
    logic [1:0]  op_kind;
    logic [7:0]  op_byte;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        busy, done, ok;
    logic [1:0]  err_code;
    logic [31:0] page_size, block_size;
    logic [15:0] spare_size;
    logic [63:0] chip_size, page_mask;
    logic [4:0]  page_shift, erase_shift;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // device model configuration
    logic [7:0]  m_mfg, m_dev, m_mfg2, m_dev2;
    logic [7:0]  m_sig [4];
    logic [31:0] m_page, m_ppb, m_bpu;
    logic [15:0] m_spare;
    logic [7:0]  m_units;

    // device model state and observation log
    logic [7:0] cur_cmd = 8'h00, cur_adr = 8'h00;
    int rd_idx = 0, id0_cnt = 0, stall = 0;
    int n_reset = 0, n_param = 0, n_sig_rd = 0, n_reads = 0, n_cmd = 0, n_adr = 0;
    logic [7:0] cmd_log [8];
    logic [7:0] adr_log [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    onfi_probe dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_byte(op_byte),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .ok(ok), .err_code(err_code),
        .page_size(page_size), .spare_size(spare_size), .block_size(block_size),
        .chip_size(chip_size), .page_shift(page_shift), .erase_shift(erase_shift),
        .page_mask(page_mask)
    );

    function automatic logic [7:0] param_byte(input int i);
        if (i >= 80 && i < 84)  return m_page[8*(i-80) +: 8];
        if (i >= 84 && i < 86)  return m_spare[8*(i-84) +: 8];
        if (i >= 92 && i < 96)  return m_ppb[8*(i-92) +: 8];
        if (i >= 96 && i < 100) return m_bpu[8*(i-96) +: 8];
        if (i == 100)           return m_units;
        return 8'hA5 ^ 8'(i);
    endfunction

    function automatic logic [7:0] dev_byte(input logic [7:0] c, input logic [7:0] a, input int i, input int idn);
        if (c == 8'h90 && a == 8'h00) begin
            if (i == 0) return (idn == 1) ? m_mfg : m_mfg2;
            if (i == 1) return (idn == 1) ? m_dev : m_dev2;
            return 8'h30 + 8'(i);
        end
        if (c == 8'h90 && a == 8'h20) return (i < 4) ? m_sig[i] : 8'h00;
        if (c == 8'hEC) return param_byte(i);
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        rd_valid <= 1'b0;
        stall    <= stall + 1;
        op_ready <= ((stall % 4) != 3);
        if (op_valid && op_ready) begin
            case (op_kind)
                2'd0: begin
                    cur_cmd <= op_byte;
                    rd_idx  <= 0;
                    if (n_cmd < 8) cmd_log[n_cmd] <= op_byte;
                    n_cmd   <= n_cmd + 1;
                    if (op_byte == 8'hFF) n_reset <= n_reset + 1;
                    if (op_byte == 8'hEC) n_param <= n_param + 1;
                end
                2'd1: begin
                    cur_adr <= op_byte;
                    if (n_adr < 8) adr_log[n_adr] <= op_byte;
                    n_adr   <= n_adr + 1;
                    if (cur_cmd == 8'h90 && op_byte == 8'h00) id0_cnt <= id0_cnt + 1;
                end
                default: begin
                    rd_valid <= 1'b1;
                    rd_data  <= dev_byte(cur_cmd, cur_adr, rd_idx, id0_cnt);
                    rd_idx   <= rd_idx + 1;
                    n_reads  <= n_reads + 1;
                    if (cur_cmd == 8'h90 && cur_adr == 8'h20) n_sig_rd <= n_sig_rd + 1;
                end
            endcase
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int lsb_of(input logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic set_device(input logic [31:0] pg, input logic [15:0] sp, input logic [31:0] ppb,
                              input logic [31:0] bpu, input logic [7:0] un);
        m_mfg = 8'h2C; m_dev = 8'hDA; m_mfg2 = 8'h2C; m_dev2 = 8'hDA;
        m_sig[0] = 8'h4F; m_sig[1] = 8'h4E; m_sig[2] = 8'h46; m_sig[3] = 8'h49;
        m_page = pg; m_spare = sp; m_ppb = ppb; m_bpu = bpu; m_units = un;
    endtask

    task automatic clear_log();
        @(negedge clk);
        n_reset = 0; n_param = 0; n_sig_rd = 0; n_reads = 0; n_cmd = 0; n_adr = 0; id0_cnt = 0;
    endtask

    task automatic run_probe();
        clear_log();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && done === 1'b0, "R10", "busy after start", {62'd0, busy, done}, 64'd2);
        while (done !== 1'b1) @(negedge clk);
    endtask

    task automatic expect_success(input string tag);
        logic [31:0] eb;
        logic [63:0] ec, em;
        int eps, ees;
        eb  = m_page * m_ppb;
        ec  = 64'(m_bpu) * 64'(eb) * 64'(m_units);
        eps = lsb_of(64'(m_page));
        ees = lsb_of(64'(eb));
        em  = (ec >> eps) - 64'd1;
        check(ok === 1'b1 && err_code === 2'd0, "R10", {tag, " ok/err"}, {61'd0, ok, err_code}, 64'd4);
        check(page_size === m_page && spare_size === m_spare, "R5", {tag, " page/spare"},
              {page_size, 16'd0, spare_size}, {m_page, 16'd0, m_spare});
        check(block_size === eb, "R6", {tag, " block"}, 64'(block_size), 64'(eb));
        check(chip_size === ec, "R6", {tag, " chip"}, chip_size, ec);
        check(page_shift === 5'(eps) && erase_shift === 5'(ees), "R7", {tag, " shifts"},
              {54'd0, page_shift, erase_shift}, {54'd0, 5'(eps), 5'(ees)});
        check(page_mask === em, "R8", {tag, " mask"}, page_mask, em);
        check(n_reads == 115 && n_param == 1 && n_reset == 1, "R5", {tag, " read count"},
              64'(n_reads), 64'd115);
    endtask

    task automatic expect_error(input string req, input logic [1:0] code, input int sig_rd);
        check(ok === 1'b0 && err_code === code, req, "error code", {62'd0, err_code}, {62'd0, code});
        check(page_size === 0 && block_size === 0 && chip_size === 0 && page_mask === 0,
              "R10", "geometry zero on error", chip_size, 64'd0);
        check(n_param == 0 && n_sig_rd == sig_rd, req, "signature reads / no param cmd",
              64'(n_sig_rd), 64'(sig_rd));
        repeat (6) @(negedge clk);
        check(done === 1'b1 && busy === 1'b0, "R10", "done holds", {62'd0, done, busy}, 64'd2);
    endtask

    task automatic t_reset_state();
        check(!busy && !done && !ok && err_code == 2'd0, "R1", "control after reset",
              {60'd0, busy, done, ok, err_code[0]}, 64'd0);
        check(page_size == 0 && chip_size == 0 && page_mask == 0 && block_size == 0,
              "R1", "geometry after reset", chip_size, 64'd0);
    endtask

    task automatic t_basic();
        set_device(32'd2048, 16'd64, 32'd64, 32'd1024, 8'd1);
        run_probe();
        expect_success("small");
        check(cmd_log[0] == 8'hFF && cmd_log[1] == 8'h90 && cmd_log[2] == 8'h90 &&
              cmd_log[3] == 8'h90 && cmd_log[4] == 8'hEC && n_cmd == 5, "R2", "command order",
              {24'd0, cmd_log[0], cmd_log[1], cmd_log[2], cmd_log[3], cmd_log[4]},
              64'hFF909090EC);
        check(adr_log[0] == 8'h00 && adr_log[1] == 8'h00 && adr_log[2] == 8'h20 &&
              adr_log[3] == 8'h00 && n_adr == 4, "R3", "address order",
              {32'd0, adr_log[0], adr_log[1], adr_log[2], adr_log[3]}, 64'h00002000);
        check(n_sig_rd == 4, "R4", "signature read count", 64'(n_sig_rd), 64'd4);
    endtask

    task automatic t_large();
        set_device(32'd4096, 16'd224, 32'd128, 32'd4096, 8'd4);
        run_probe();
        expect_success("large");
    endtask

    task automatic t_odd_page();
        set_device(32'h3000, 16'd448, 32'd96, 32'd100, 8'd3);
        run_probe();
        expect_success("odd");
    endtask

    task automatic t_id_mismatch_mfg();
        set_device(32'd2048, 16'd64, 32'd64, 32'd1024, 8'd1);
        m_mfg2 = 8'h98;
        run_probe();
        expect_error("R3", 2'd1, 0);
        check(n_reads == 10, "R3", "reads before id error", 64'(n_reads), 64'd10);
    endtask

    task automatic t_id_mismatch_dev();
        set_device(32'd2048, 16'd64, 32'd64, 32'd1024, 8'd1);
        m_dev2 = 8'hD3;
        run_probe();
        expect_error("R3", 2'd1, 0);
    endtask

    task automatic t_sig_bad(input int pos);
        set_device(32'd2048, 16'd64, 32'd64, 32'd1024, 8'd1);
        m_sig[pos] = 8'h20;
        run_probe();
        expect_error("R4", 2'd2, pos + 1);
    endtask

    task automatic t_start_while_busy();
        set_device(32'd8192, 16'd640, 32'd256, 32'd2048, 8'd2);
        clear_log();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done !== 1'b1) @(negedge clk);
        check(n_reset == 1 && n_cmd == 5, "R2", "start while busy ignored", 64'(n_cmd), 64'd5);
        expect_success("restart-ignored");
    endtask

    task automatic t_stall_hold();
        // sequencer stalls every fourth cycle throughout; a dropped op would break the log
        set_device(32'd512, 16'd16, 32'd32, 32'd4096, 8'd1);
        run_probe();
        check(n_reads == 115 && n_cmd == 5 && n_adr == 4, "R9", "ops under stalls",
              64'(n_reads), 64'd115);
        expect_success("stall");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        set_device(32'd2048, 16'd64, 32'd64, 32'd1024, 8'd1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_large();
        t_odd_page();
        t_id_mismatch_mfg();
        t_id_mismatch_dev();
        t_sig_bad(0);
        t_sig_bad(2);
        t_basic();
        t_start_while_busy();
        t_stall_hold();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule